// File: doc/BRIEF.md
# Macro Instruction Sequencer

This block runs one macro call from its first instruction to its end. A start pulse carries the first call argument. The block clears the register file and writes that argument into register 1. It then reads 32-bit instruction words from a synchronous instruction RAM that sits outside the block. The RAM returns the word one clock after the address is presented. The block also receives the number of loaded words.

Each word is either a control word or a value-producing word. A control word is a conditional branch, tested on one register. A taken branch runs the next word as a delay slot before it jumps to the target, unless that branch turns the slot off. A value-producing word goes to a neighbouring execution block over a valid/result handshake. The sequencer presents the word, its index and both operand values, and holds them until the neighbour answers. It then writes the returned result into the destination register. A value-producing word can also carry an exit flag. The following word still runs as a delay slot, and then the call ends.

The call also ends when control leaves the loaded range. The block signals the end with a one-cycle done pulse.

Top module: `macro_seq`

## Requirements
- R1: After reset, busy, done and exec_valid are all low, and no RAM fetch is made until start.
- R2: A start pulse in idle sets register 1 to start_arg and registers 2 to 7 to zero before the first word executes. A start pulse while busy has no effect on the running call.
- R3: Register 0 always reads as zero. A result with destination index 0 is discarded.
- R4: A word whose bits 2:0 are not 7 is issued with exec_valid high, together with exec_pc, exec_instr, and the values of the registers indexed by bits 13:11 (exec_a) and 16:14 (exec_b). These stay stable until exec_done is sampled high. exec_result is then written to the register indexed by bits 10:8.
- R5: A word whose bits 2:0 equal 7 is a branch. Its target index is its own index plus the two's-complement value of bits 31:14. It makes no exec request.
- R6: Branch bit 4 selects the condition. With 1, the branch is taken when the register indexed by bits 13:11 is nonzero. With 0, it is taken when that register is zero. A branch that is not taken continues at the next index.
- R7: A taken branch with bit 5 = 1 jumps straight to the target. With bit 5 = 0, the word at the next index runs first and then control moves to the target.
- R8: A value-producing word with bit 7 set runs the word at the next index as a delay slot and then ends the call. Bit 7 of a branch is ignored.
- R9: In a delay slot, bits 7, 5 and 4 carry no control meaning. A branch encoding in a delay slot is a no-op that makes no exec request and writes no register.
- R10: When the next index is negative or not below prog_len, the call ends. This covers a fall-through, a branch target and an exit delay slot.
- R11: The end of a call raises done for exactly one cycle, with busy low in that same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin a call (taken only when idle) |
| start_arg | input | 32 | First call argument, loaded into register 1 |
| prog_len | input | PW+1 | Number of loaded instruction words |
| imem_addr | output | PW | Instruction RAM read address |
| imem_data | input | 32 | Instruction RAM read data, one cycle after the address |
| exec_valid | output | 1 | Value-producing word awaiting the neighbour |
| exec_pc | output | PW | Index of the issued word |
| exec_instr | output | 32 | Issued word |
| exec_a | output | 32 | Operand A value |
| exec_b | output | 32 | Operand B value |
| exec_done | input | 1 | Neighbour has a result this cycle |
| exec_result | input | 32 | Result to write to the destination register |
| busy | output | 1 | A call is running |
| done | output | 1 | One-cycle end-of-call pulse |

## Verification
The hardest cases to reach from the ports are delay slots holding words that would otherwise steer control. Examples are a branch inside a taken branch's slot, an exit slot that lies past the last loaded word, and a target outside the loaded range. Reaching them takes exact register contents at the moment of each branch. The neighbour model returns results that are a known function of the word and its operands, and some words force a zero result, so the bench can drive branch conditions both ways. Directed programs place branches and exits directly in slots, at the last index and with out-of-range offsets. Random programs with forward-only branches mix these patterns and are checked request by request against a reference model.

// File: rtl/msq_pkg.sv
package msq_pkg;
  localparam int unsigned WORD_W    = 32;
  localparam int unsigned NUM_REGS  = 8;
  localparam int unsigned RIDX_W    = $clog2(NUM_REGS);
  localparam int unsigned OFFS_LSB  = 14;
  localparam int unsigned OFFS_W    = WORD_W - OFFS_LSB;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_FETCH,
    ST_DECODE,
    ST_EXEC
  } msq_state_e;

  typedef struct packed {
    logic              is_branch;
    logic              cond_nz;
    logic              no_slot;
    logic              exit_f;
    logic [RIDX_W-1:0] ra;
    logic [RIDX_W-1:0] rb;
    logic [RIDX_W-1:0] rd;
  } msq_fields_t;
endpackage

// File: rtl/msq_decode.sv
module msq_decode
  import msq_pkg::*;
#(
  parameter int unsigned PW = 6
) (
  input  logic [WORD_W-1:0] instr,
  input  logic [PW-1:0]     idx,
  output msq_fields_t       fld,
  output logic [WORD_W-1:0] target
);
  logic [WORD_W-1:0] offs_ext;

  always_comb begin
    fld.is_branch = (instr[2:0] == 3'd7);
    fld.cond_nz   = instr[4];
    fld.no_slot   = instr[5];
    fld.exit_f    = instr[7];
    fld.rd        = instr[10:8];
    fld.ra        = instr[13:11];
    fld.rb        = instr[16:14];
    offs_ext      = {{OFFS_LSB{instr[WORD_W-1]}}, instr[WORD_W-1:OFFS_LSB]};
    target        = {{(WORD_W-PW){1'b0}}, idx} + offs_ext;
  end
endmodule

// File: rtl/msq_regfile.sv
module msq_regfile
  import msq_pkg::*;
#(
  parameter int unsigned W = WORD_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              clr,
  input  logic [W-1:0]      clr_val,
  input  logic              we,
  input  logic [RIDX_W-1:0] waddr,
  input  logic [W-1:0]      wdata,
  input  logic [RIDX_W-1:0] raddr_a,
  input  logic [RIDX_W-1:0] raddr_b,
  output logic [W-1:0]      rdata_a,
  output logic [W-1:0]      rdata_b
);
  logic [NUM_REGS-1:0][W-1:0] regv;

  for (genvar i = 0; i < NUM_REGS; i++) begin : g_reg
    if (i == 0) begin : g_zero
      assign regv[i] = '0;
    end else begin : g_store
      logic [W-1:0] q;
      always_ff @(posedge clk) begin
        if (rst) begin
          q <= '0;
        end else if (clr) begin
          q <= (i == 1) ? clr_val : '0;
        end else if (we && (waddr == RIDX_W'(i))) begin
          q <= wdata;
        end
      end
      assign regv[i] = q;
    end
  end

  assign rdata_a = regv[raddr_a];
  assign rdata_b = regv[raddr_b];

  a_r2_arg_load: assert property (@(posedge clk) disable iff (rst)
    clr |=> (regv[1] == $past(clr_val)) && (regv[2] == '0) && (regv[7] == '0));

  a_r4_result_write: assert property (@(posedge clk) disable iff (rst)
    (we && !clr && waddr != '0) |=> (regv[$past(waddr)] == $past(wdata)));

  a_r3_zero_entry: assert property (@(posedge clk) disable iff (rst)
    (we && waddr == '0) |=> (regv[0] == '0));
endmodule

// File: rtl/msq_range.sv
module msq_range
  import msq_pkg::*;
#(
  parameter int unsigned PW = 6
) (
  input  logic [WORD_W-1:0] nxt_idx,
  input  logic [PW:0]       prog_len,
  input  logic              force_end,
  output logic              stop
);
  logic in_range;

  always_comb begin
    in_range = !nxt_idx[WORD_W-1] && (nxt_idx < {{(WORD_W-PW-1){1'b0}}, prog_len});
    stop     = force_end || !in_range;
  end
endmodule

// File: rtl/macro_seq.sv
module macro_seq
  import msq_pkg::*;
#(
  parameter  int unsigned DEPTH = 64,
  localparam int unsigned PW    = $clog2(DEPTH)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start,
  input  logic [31:0]       start_arg,
  input  logic [PW:0]       prog_len,
  output logic [PW-1:0]     imem_addr,
  input  logic [31:0]       imem_data,
  output logic              exec_valid,
  output logic [PW-1:0]     exec_pc,
  output logic [31:0]       exec_instr,
  output logic [31:0]       exec_a,
  output logic [31:0]       exec_b,
  input  logic              exec_done,
  input  logic [31:0]       exec_result,
  output logic              busy,
  output logic              done
);
  msq_state_e        state;
  logic [PW-1:0]     pc;
  logic              in_slot;
  logic              slot_end;
  logic [WORD_W-1:0] slot_tgt;

  msq_fields_t       fld;
  logic [WORD_W-1:0] br_target;
  logic [WORD_W-1:0] rd_a, rd_b;
  logic              taken;

  logic              adv_req, adv_end, set_slot, clr_slot, slot_end_n, issue, stop;
  logic [WORD_W-1:0] adv_idx, slot_tgt_n;
  logic              rf_we;
  logic [RIDX_W-1:0] rf_waddr;

  msq_decode #(.PW(PW)) u_dec (
    .instr  (imem_data),
    .idx    (pc),
    .fld    (fld),
    .target (br_target)
  );

  assign rf_we    = (state == ST_EXEC) && exec_done && (exec_instr[10:8] != '0);
  assign rf_waddr = exec_instr[10:8];

  msq_regfile #(.W(WORD_W)) u_rf (
    .clk     (clk),
    .rst     (rst),
    .clr     ((state == ST_IDLE) && start),
    .clr_val (start_arg),
    .we      (rf_we),
    .waddr   (rf_waddr),
    .wdata   (exec_result),
    .raddr_a (fld.ra),
    .raddr_b (fld.rb),
    .rdata_a (rd_a),
    .rdata_b (rd_b)
  );

  assign taken = fld.cond_nz ? (rd_a != '0) : (rd_a == '0);

  always_comb begin
    adv_req    = 1'b0;
    adv_end    = 1'b0;
    adv_idx    = {{(WORD_W-PW){1'b0}}, pc} + 32'd1;
    set_slot   = 1'b0;
    clr_slot   = 1'b0;
    slot_end_n = 1'b0;
    slot_tgt_n = '0;
    issue      = 1'b0;
    unique case (state)
      ST_DECODE: begin
        if (fld.is_branch) begin
          adv_req = 1'b1;
          if (in_slot) begin
            clr_slot = 1'b1;
            adv_end  = slot_end;
            adv_idx  = slot_tgt;
          end else if (taken && fld.no_slot) begin
            adv_idx = br_target;
          end else if (taken) begin
            set_slot   = 1'b1;
            slot_tgt_n = br_target;
          end
        end else begin
          issue = 1'b1;
        end
      end
      ST_EXEC: begin
        if (exec_done) begin
          adv_req = 1'b1;
          if (in_slot) begin
            clr_slot = 1'b1;
            adv_end  = slot_end;
            adv_idx  = slot_tgt;
          end else if (exec_instr[7]) begin
            set_slot   = 1'b1;
            slot_end_n = 1'b1;
          end
        end
      end
      default: ;
    endcase
  end

  msq_range #(.PW(PW)) u_range (
    .nxt_idx   (adv_idx),
    .prog_len  (prog_len),
    .force_end (adv_end),
    .stop      (stop)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      state      <= ST_IDLE;
      pc         <= '0;
      imem_addr  <= '0;
      in_slot    <= 1'b0;
      slot_end   <= 1'b0;
      slot_tgt   <= '0;
      exec_valid <= 1'b0;
      exec_pc    <= '0;
      exec_instr <= '0;
      exec_a     <= '0;
      exec_b     <= '0;
      busy       <= 1'b0;
      done       <= 1'b0;
    end else begin
      done <= 1'b0;
      if (state == ST_IDLE) begin
        if (start) begin
          state     <= ST_FETCH;
          pc        <= '0;
          imem_addr <= '0;
          in_slot   <= 1'b0;
          busy      <= 1'b1;
        end
      end else if (state == ST_FETCH) begin
        state <= ST_DECODE;
      end
      if (issue) begin
        exec_valid <= 1'b1;
        exec_pc    <= pc;
        exec_instr <= imem_data;
        exec_a     <= rd_a;
        exec_b     <= rd_b;
        state      <= ST_EXEC;
      end
      if (state == ST_EXEC && exec_done) begin
        exec_valid <= 1'b0;
      end
      if (set_slot) begin
        in_slot  <= 1'b1;
        slot_end <= slot_end_n;
        slot_tgt <= slot_tgt_n;
      end else if (clr_slot) begin
        in_slot <= 1'b0;
      end
      if (adv_req) begin
        if (stop) begin
          state   <= ST_IDLE;
          busy    <= 1'b0;
          done    <= 1'b1;
          in_slot <= 1'b0;
        end else begin
          state     <= ST_FETCH;
          pc        <= adv_idx[PW-1:0];
          imem_addr <= adv_idx[PW-1:0];
        end
      end
    end
  end

  a_r4_hold_request: assert property (@(posedge clk) disable iff (rst)
    (exec_valid && !exec_done) |=> exec_valid && $stable(exec_instr) && $stable(exec_a)
                                   && $stable(exec_b) && $stable(exec_pc));

  a_r9_no_branch_issue: assert property (@(posedge clk) disable iff (rst)
    exec_valid |-> (exec_instr[2:0] != 3'd7));

  a_r3_zero_operand: assert property (@(posedge clk) disable iff (rst)
    (exec_valid && exec_instr[13:11] == '0) |-> (exec_a == '0));

  a_r11_done_pulse: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);

  a_r11_done_idle: assert property (@(posedge clk) disable iff (rst)
    done |-> !busy);

  a_r10_fetch_in_range: assert property (@(posedge clk) disable iff (rst)
    (state == ST_FETCH) |-> ({1'b0, imem_addr} < prog_len));
endmodule

// File: tb/tb_macro_seq.sv
module tb_macro_seq;
  localparam int unsigned DEPTH = 64;
  localparam int unsigned PW    = $clog2(DEPTH);
  localparam time         TCK   = 20ns;

  logic          clk = 1'b0;
  logic          rst;
  logic          start;
  logic [31:0]   start_arg;
  logic [PW:0]   prog_len;
  logic [PW-1:0] imem_addr;
  logic [31:0]   imem_data;
  logic          exec_valid;
  logic [PW-1:0] exec_pc;
  logic [31:0]   exec_instr, exec_a, exec_b;
  logic          exec_done;
  logic [31:0]   exec_result;
  logic          busy, done;

  int checks = 0;
  int fails  = 0;

  logic [31:0] prog [DEPTH];
  int          exp_n;
  int          exp_pc [64];
  logic [31:0] exp_in [64];
  logic [31:0] exp_a  [64];
  logic [31:0] exp_b  [64];

  always #(TCK/2) clk = ~clk;

  always @(posedge clk) imem_data <= prog[imem_addr];

  macro_seq #(.DEPTH(DEPTH)) dut (
    .clk(clk), .rst(rst), .start(start), .start_arg(start_arg), .prog_len(prog_len),
    .imem_addr(imem_addr), .imem_data(imem_data), .exec_valid(exec_valid),
    .exec_pc(exec_pc), .exec_instr(exec_instr), .exec_a(exec_a), .exec_b(exec_b),
    .exec_done(exec_done), .exec_result(exec_result), .busy(busy), .done(done)
  );

  function automatic logic [31:0] nb_res(logic [31:0] w, logic [31:0] a, logic [31:0] b);
    if (w[23]) return 32'd0;
    return a + b + {{24{w[31]}}, w[31:24]};
  endfunction

  function automatic logic [31:0] alu(int rd, int ra, int rb, int imm, bit z, bit ex);
    logic [31:0] w;
    w = '0;
    w[31:24] = imm[7:0];
    w[23]    = z;
    w[16:14] = rb[2:0];
    w[13:11] = ra[2:0];
    w[10:8]  = rd[2:0];
    w[7]     = ex;
    return w;
  endfunction

  function automatic logic [31:0] br(int ra, int off, bit nz, bit noslot, bit ex);
    logic [31:0] w;
    w = '0;
    w[31:14] = off[17:0];
    w[13:11] = ra[2:0];
    w[7]     = ex;
    w[5]     = noslot;
    w[4]     = nz;
    w[2:0]   = 3'd7;
    return w;
  endfunction

  task automatic model_run(logic [31:0] arg, int len);
    logic [31:0] r [8];
    int pc, stgt, steps;
    bit slot, send, tk;
    logic [31:0] w, a, b;
    for (int i = 0; i < 8; i++) r[i] = '0;
    r[1] = arg; pc = 0; slot = 0; send = 0; stgt = 0; exp_n = 0; steps = 0;
    while (steps < 400) begin
      steps++;
      if (pc < 0 || pc >= len) break;
      w = prog[pc];
      if (w[2:0] == 3'd7) begin
        if (slot) begin
          slot = 0;
          if (send) break;
          pc = stgt;
        end else begin
          a  = r[w[13:11]];
          tk = w[4] ? (a != 0) : (a == 0);
          if (tk && w[5]) pc = pc + $signed(w[31:14]);
          else if (tk) begin slot = 1; send = 0; stgt = pc + $signed(w[31:14]); pc++; end
          else pc++;
        end
      end else begin
        a = r[w[13:11]]; b = r[w[16:14]];
        if (exp_n < 64) begin
          exp_pc[exp_n] = pc; exp_in[exp_n] = w; exp_a[exp_n] = a; exp_b[exp_n] = b;
        end
        exp_n++;
        if (w[10:8] != 0) r[w[10:8]] = nb_res(w, a, b);
        if (slot) begin
          slot = 0;
          if (send) break;
          pc = stgt;
        end else if (w[7]) begin slot = 1; send = 1; pc++; end
        else pc++;
      end
    end
  endtask

  task automatic chk(bit ok, string tag, string what, logic [31:0] act, logic [31:0] expv);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s actual=%h expected=%h", tag, what, act, expv);
    end
  endtask

  task automatic run_call(logic [31:0] arg, int len, string tag, bit stray);
    int k, dly, cyc;
    bit pend, got;
    prog_len = len[PW:0];
    model_run(arg, len);
    @(negedge clk);
    start = 1'b1; start_arg = arg;
    k = 0; pend = 0; got = 0; dly = 0;
    for (cyc = 0; cyc < 3000; cyc++) begin
      @(negedge clk);
      start = (stray && cyc == 4) ? 1'b1 : 1'b0;
      start_arg = arg ^ 32'h5a5a_0f0f;
      exec_done = 1'b0;
      if (done) begin got = 1; break; end
      if (exec_valid && !pend) begin
        pend = 1; dly = int'($urandom % 3);
        if (k < exp_n && k < 64) begin
          chk(exec_pc == exp_pc[k][PW-1:0], tag, "exec_pc", 32'(exec_pc), exp_pc[k]);
          chk(exec_instr == exp_in[k], tag, "exec_instr", exec_instr, exp_in[k]);
          chk(exec_a == exp_a[k], tag, "exec_a", exec_a, exp_a[k]);
          chk(exec_b == exp_b[k], tag, "exec_b", exec_b, exp_b[k]);
        end
        k++;
      end
      if (pend) begin
        if (dly == 0) begin
          exec_done = 1'b1; exec_result = nb_res(exec_instr, exec_a, exec_b); pend = 0;
        end else dly--;
      end
    end
    start = 1'b0; exec_done = 1'b0;
    chk(got, tag, "done seen", 32'(got), 1);
    chk(k == exp_n, tag, "exec count", k, exp_n);
    chk(!busy, tag, "busy at done", 32'(busy), 0);
    @(negedge clk);
    chk(!done, "R11", "done width", 32'(done), 0);
  endtask

  initial begin
    #(TCK * 150000);
    fails++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    void'($urandom(32'd1234));
    for (int i = 0; i < DEPTH; i++) prog[i] = '0;
    rst = 1'b1; start = 1'b0; start_arg = '0; prog_len = '0;
    exec_done = 1'b0; exec_result = '0;
    repeat (4) @(negedge clk);
    rst = 1'b0;
    repeat (3) @(negedge clk);
    // R1 reset state
    chk(!busy && !done && !exec_valid, "R1", "outputs idle", {busy, done, exec_valid}, 0);
    chk(imem_addr == '0, "R1", "imem_addr", 32'(imem_addr), 0);

    // R2 R4 argument in register 1, operand routing, fall off end (R10)
    prog[0] = alu(2, 1, 0, 0, 0, 0);
    prog[1] = alu(3, 2, 1, 5, 0, 0);
    prog[2] = alu(4, 3, 7, 0, 0, 0);
    run_call(32'h0000_1234, 3, "R2", 0);
    // R3 destination 0 discarded, register 0 reads zero
    prog[0] = alu(0, 1, 1, 7, 0, 0);
    prog[1] = alu(4, 0, 0, 0, 0, 0);
    run_call(32'h99, 2, "R3", 0);
    // R2 registers cleared between calls: r3,r4 read back as zero
    prog[0] = alu(5, 3, 4, 0, 0, 0);
    run_call(32'h7, 1, "R2", 0);
    // R5 R6 R7 taken branch with delay slot
    prog[0] = alu(2, 1, 0, 0, 0, 0);
    prog[1] = br(2, 3, 1, 0, 0);
    prog[2] = alu(5, 1, 1, 0, 0, 0);
    prog[3] = alu(6, 1, 0, 1, 0, 0);
    prog[4] = alu(6, 5, 2, 0, 0, 0);
    run_call(32'h10, 5, "R7", 0);
    // R6 not taken when register zero (nonzero condition)
    run_call(32'h0, 5, "R6", 0);
    // R7 no delay slot
    prog[1] = br(2, 2, 1, 1, 0);
    run_call(32'h10, 5, "R7", 0);
    // R6 zero condition taken on zero, R8 branch exit bit ignored
    prog[1] = br(2, 3, 0, 1, 1);
    run_call(32'h0, 5, "R6", 0);
    run_call(32'h3, 5, "R8", 0);
    // R8 exit with delay slot
    prog[0] = alu(2, 1, 0, 0, 0, 1);
    prog[1] = alu(3, 2, 1, 0, 0, 0);
    prog[2] = alu(4, 3, 0, 0, 0, 0);
    run_call(32'h21, 3, "R8", 0);
    // R9 branch in delay slot is a no-op; exit bit in a slot ignored
    prog[0] = br(0, 3, 0, 0, 0);
    prog[1] = br(0, 1, 0, 1, 0);
    prog[2] = alu(2, 1, 0, 0, 0, 0);
    prog[3] = alu(3, 1, 1, 0, 0, 0);
    prog[4] = br(0, 2, 0, 0, 0);
    prog[5] = alu(4, 3, 0, 0, 0, 1);
    prog[6] = alu(5, 4, 0, 0, 0, 0);
    prog[7] = alu(6, 5, 0, 0, 0, 0);
    run_call(32'h44, 8, "R9", 0);
    // R10 exit on last word, slot lies outside the program
    prog[0] = alu(2, 1, 0, 0, 0, 1);
    run_call(32'h5, 1, "R10", 0);
    // R10 negative target and target past end
    prog[0] = br(0, -1, 0, 1, 0);
    run_call(32'h5, 3, "R10", 0);
    prog[0] = br(0, 9, 0, 0, 0);
    prog[1] = alu(2, 1, 0, 0, 0, 0);
    run_call(32'h5, 3, "R10", 0);
    // R5 backward loop counting down, plus R2 stray start while busy
    prog[0] = alu(2, 1, 0, 0, 0, 0);
    prog[1] = alu(2, 2, 0, 8'hff, 0, 0);
    prog[2] = br(2, -1, 1, 1, 0);
    prog[3] = alu(3, 2, 1, 0, 0, 1);
    prog[4] = alu(4, 1, 3, 0, 0, 0);
    prog[5] = alu(5, 1, 1, 0, 0, 0);
    run_call(32'h5, 6, "R5", 0);
    run_call(32'h4, 6, "R2", 1);

    // random forward-branching programs
    for (int t = 0; t < 40; t++) begin
      int len;
      len = 4 + int'($urandom % 13);
      for (int i = 0; i < len; i++) begin
        int r;
        r = int'($urandom % 10);
        if (r < 6)
          prog[i] = alu(int'($urandom % 8), int'($urandom % 8), int'($urandom % 8),
                        int'($urandom % 256), ($urandom % 4) == 0, ($urandom % 8) == 0);
        else
          prog[i] = br(int'($urandom % 8), 1 + int'($urandom % 3), $urandom % 2 == 1,
                       $urandom % 2 == 1, $urandom % 4 == 0);
      end
      run_call($urandom % 3 == 0 ? 32'h0 : $urandom, len, "R4", 0);
    end

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule